// File: doc/BRIEF.md
# Lockable Pad Configuration Bank

This block is the configuration store for one port of eight pads. Software reaches it through a simple word-addressed register bus. For every pin it holds a direction bit, a digital-enable bit and an analog-select bit. It also holds a pull-up and pull-down pair, an open-drain select, three drive-strength selects, a slew-control bit and an alternate-function enable. A 32-bit function-select word gives each pin a 4-bit function number. The stored state drives a set of pad-control vectors continuously, so pad logic elsewhere on the chip can consume them directly.

Two groups of selects keep themselves consistent in hardware. Setting a pull bit clears the opposite pull bit of the same pin. Setting one drive-strength bit clears that pin's bit in the other two drive registers. Some pins are protected; at reset they are in alternate-function mode. A key register and a commit mask decide whether their pull, digital-enable and alternate-function bits may be changed. The commit mask can only be written while the key register holds the unlock value.

Top module: `padcfg_bank`

## Requirements
- R1: The register offsets are 0 direction, 1 digital enable, 2 analog select, 3 pull-up, 4 pull-down, 5 open-drain, 6 drive 2 mA, 7 drive 4 mA, 8 drive 8 mA, 9 slew, 10 alternate-function enable, 11 function select, 12 lock, 13 commit. Reads of offsets 14 and 15 return 0, and reads return register bits in bits [7:0] (function select uses all 32 bits).
- R2: Writing the pull-up register sets each pin's pull-up bit to the written value, and clears the pull-down bit of every pin written with 1. Writing the pull-down register does the same with the roles of the two registers swapped. No pin ever has both pull bits set.
- R3: Writing one of the three drive registers loads it and clears, in the other two, every pin written with 1. At most one drive bit is set per pin.
- R4: After reset, direction, analog select, pull bits, open-drain, 4 mA, 8 mA and slew are all 0. Digital enable and 2 mA drive are all 1. The alternate-function enable equals the protected-pin mask, and each protected pin's function field is 1 while every other field is 0.
- R5: Writing 0x4C4F434B to the lock register unlocks it, and writing any other value locks it. A read of the lock register returns 0 when unlocked and 1 when locked. A commit write while locked has no effect.
- R6: While a protected pin's commit bit is 0, writes to digital enable, alternate-function enable, pull-up and pull-down leave that pin's bit in the written register unchanged. Such a write also does not clear that pin's opposite pull bit.
- R7: Pin i's function number is function-select bits [4i+3:4i]. The alternate-function output of pin i is 1 only when its enable bit is set and its function number is not 0.
- R8: The slew output of a pin is 1 only when both its slew bit and its 8 mA drive bit are set.
- R9: The commit mask resets to the complement of the protected-pin mask. Once a protected pin's commit bit has been set, writes to its gated bits take effect.
- R10: Direction, analog select, open-drain, slew and function select are loaded in full by a write and read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_we_i | input | 1 | Write strobe, one write per cycle |
| bus_addr_i | input | 4 | Word offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i (combinational) |
| pad_dir_o | output | 8 | 1 = output |
| pad_den_o | output | 8 | Digital enable |
| pad_ana_o | output | 8 | Analog select |
| pad_pu_o | output | 8 | Pull-up enable |
| pad_pd_o | output | 8 | Pull-down enable |
| pad_od_o | output | 8 | Open-drain select |
| pad_dr2_o | output | 8 | 2 mA drive select |
| pad_dr4_o | output | 8 | 4 mA drive select |
| pad_dr8_o | output | 8 | 8 mA drive select |
| pad_slew_o | output | 8 | Effective slew control |
| pad_af_o | output | 8 | Effective alternate-function selection |
| pad_fsel_o | output | 32 | Function-select word |

## Verification
The bench uses the default parameters: eight pins, 4-bit function fields, and protected pins 0 and 3. This mixes gated and ungated pins inside every written byte, so each gated register write exercises both behaviours at once. Directed steps cover the reset values, commit writes while locked, and gated writes before and after committing. They also cover a function number of zero with the enable set, and slew losing effect when 8 mA is cleared. Random writes then mix unlock keys and commit updates, so protected pins move between gated and free states many times.

// File: rtl/padcfg_pkg.sv
package padcfg_pkg;
  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    RA_DIR    = 4'd0,
    RA_DEN    = 4'd1,
    RA_ANA    = 4'd2,
    RA_PUP    = 4'd3,
    RA_PDN    = 4'd4,
    RA_ODN    = 4'd5,
    RA_DRV2   = 4'd6,
    RA_DRV4   = 4'd7,
    RA_DRV8   = 4'd8,
    RA_SLEW   = 4'd9,
    RA_AFEN   = 4'd10,
    RA_FSEL   = 4'd11,
    RA_LOCK   = 4'd12,
    RA_COMMIT = 4'd13
  } reg_addr_e;
endpackage

// File: rtl/padcfg_excl_group.sv
// A group of N per-pin registers where a written 1 in one member clears
// the same pin in every sibling. Bits outside wmask_i are never touched.
module padcfg_excl_group #(
  parameter int                W   = 8,
  parameter int                N   = 2,
  parameter logic [N*W-1:0]    RST = '0
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [N-1:0]          wr_sel_i,
  input  logic [W-1:0]          wdata_i,
  input  logic [W-1:0]          wmask_i,
  output logic [N-1:0][W-1:0]   q_o
);
  function automatic logic [W-1:0] merge(input logic [W-1:0] old_v,
                                         input logic [W-1:0] new_v,
                                         input logic [W-1:0] m);
    return (old_v & ~m) | (new_v & m);
  endfunction

  logic [W-1:0] set_bits;
  logic         any_wr;

  assign set_bits = wdata_i & wmask_i;
  assign any_wr   = |wr_sel_i;

  for (genvar k = 0; k < N; k++) begin : g_member
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           q_o[k] <= RST[k*W +: W];
      else if (wr_sel_i[k])  q_o[k] <= merge(q_o[k], wdata_i, wmask_i);
      else if (any_wr)       q_o[k] <= q_o[k] & ~set_bits;
    end
  end
endmodule

// File: rtl/padcfg_lock_guard.sv
// Key register and commit mask; produces the per-pin write mask.
module padcfg_lock_guard #(
  parameter int              W     = 8,
  parameter logic [W-1:0]    PROT  = 8'h09,
  parameter logic [31:0]     KEY   = 32'h4C4F434B
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          key_wr_i,
  input  logic          commit_wr_i,
  input  logic [31:0]   wdata_i,
  output logic          unlocked_o,
  output logic [W-1:0]  commit_o,
  output logic [W-1:0]  gate_mask_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      unlocked_o <= 1'b0;
      commit_o   <= ~PROT;
    end else begin
      if (key_wr_i)                   unlocked_o <= (wdata_i == KEY);
      if (commit_wr_i && unlocked_o)  commit_o   <= wdata_i[W-1:0];
    end
  end

  // a pin is writable unless it is protected and not committed
  assign gate_mask_o = ~(PROT & ~commit_o);
endmodule

// File: rtl/padcfg_bank.sv
module padcfg_bank
  import padcfg_pkg::*;
#(
  parameter int                  NPINS      = 8,
  parameter int                  FSEL_W     = 4,
  parameter logic [NPINS-1:0]    PROT_MASK  = 8'h09,
  parameter logic [31:0]         UNLOCK_KEY = 32'h4C4F434B
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 bus_we_i,
  input  logic [ADDR_W-1:0]    bus_addr_i,
  input  logic [31:0]          bus_wdata_i,
  output logic [31:0]          bus_rdata_o,
  output logic [NPINS-1:0]     pad_dir_o,
  output logic [NPINS-1:0]     pad_den_o,
  output logic [NPINS-1:0]     pad_ana_o,
  output logic [NPINS-1:0]     pad_pu_o,
  output logic [NPINS-1:0]     pad_pd_o,
  output logic [NPINS-1:0]     pad_od_o,
  output logic [NPINS-1:0]     pad_dr2_o,
  output logic [NPINS-1:0]     pad_dr4_o,
  output logic [NPINS-1:0]     pad_dr8_o,
  output logic [NPINS-1:0]     pad_slew_o,
  output logic [NPINS-1:0]     pad_af_o,
  output logic [NPINS*FSEL_W-1:0] pad_fsel_o
);
  localparam int FSEL_BITS = NPINS * FSEL_W;

  function automatic logic [FSEL_BITS-1:0] fsel_reset();
    logic [FSEL_BITS-1:0] r;
    r = '0;
    for (int i = 0; i < NPINS; i++)
      if (PROT_MASK[i]) r[i*FSEL_W +: FSEL_W] = FSEL_W'(1);
    return r;
  endfunction

  function automatic logic [NPINS-1:0] merge(input logic [NPINS-1:0] old_v,
                                             input logic [NPINS-1:0] new_v,
                                             input logic [NPINS-1:0] m);
    return (old_v & ~m) | (new_v & m);
  endfunction

  // named internal events
  logic                 unlocked;
  logic [NPINS-1:0]     commit;
  logic [NPINS-1:0]     gate_mask;
  logic [NPINS-1:0]     wd;
  logic                 wr_dir, wr_den, wr_ana, wr_odn, wr_slew, wr_afen, wr_fsel;
  logic                 wr_lock, wr_commit;
  logic [1:0]           wr_pull;
  logic [2:0]           wr_drv;

  assign wd        = bus_wdata_i[NPINS-1:0];
  assign wr_dir    = bus_we_i && (bus_addr_i == RA_DIR);
  assign wr_den    = bus_we_i && (bus_addr_i == RA_DEN);
  assign wr_ana    = bus_we_i && (bus_addr_i == RA_ANA);
  assign wr_odn    = bus_we_i && (bus_addr_i == RA_ODN);
  assign wr_slew   = bus_we_i && (bus_addr_i == RA_SLEW);
  assign wr_afen   = bus_we_i && (bus_addr_i == RA_AFEN);
  assign wr_fsel   = bus_we_i && (bus_addr_i == RA_FSEL);
  assign wr_lock   = bus_we_i && (bus_addr_i == RA_LOCK);
  assign wr_commit = bus_we_i && (bus_addr_i == RA_COMMIT);
  assign wr_pull   = {bus_we_i && (bus_addr_i == RA_PDN),
                      bus_we_i && (bus_addr_i == RA_PUP)};
  assign wr_drv    = {bus_we_i && (bus_addr_i == RA_DRV8),
                      bus_we_i && (bus_addr_i == RA_DRV4),
                      bus_we_i && (bus_addr_i == RA_DRV2)};

  padcfg_lock_guard #(.W(NPINS), .PROT(PROT_MASK), .KEY(UNLOCK_KEY)) u_guard (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .key_wr_i    (wr_lock),
    .commit_wr_i (wr_commit),
    .wdata_i     (bus_wdata_i),
    .unlocked_o  (unlocked),
    .commit_o    (commit),
    .gate_mask_o (gate_mask)
  );

  logic [1:0][NPINS-1:0] pull_q;
  logic [2:0][NPINS-1:0] drv_q;

  padcfg_excl_group #(.W(NPINS), .N(2), .RST('0)) u_pull (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_sel_i (wr_pull),
    .wdata_i  (wd),
    .wmask_i  (gate_mask),
    .q_o      (pull_q)
  );

  padcfg_excl_group #(.W(NPINS), .N(3),
                      .RST({{(2*NPINS){1'b0}}, {NPINS{1'b1}}})) u_drive (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_sel_i (wr_drv),
    .wdata_i  (wd),
    .wmask_i  ({NPINS{1'b1}}),
    .q_o      (drv_q)
  );

  logic [NPINS-1:0]     dir_q, den_q, ana_q, odn_q, slew_q, afen_q;
  logic [FSEL_BITS-1:0] fsel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q  <= '0;
      den_q  <= '1;
      ana_q  <= '0;
      odn_q  <= '0;
      slew_q <= '0;
      afen_q <= PROT_MASK;
      fsel_q <= fsel_reset();
    end else begin
      if (wr_dir)  dir_q  <= wd;
      if (wr_den)  den_q  <= merge(den_q, wd, gate_mask);
      if (wr_ana)  ana_q  <= wd;
      if (wr_odn)  odn_q  <= wd;
      if (wr_slew) slew_q <= wd;
      if (wr_afen) afen_q <= merge(afen_q, wd, gate_mask);
      if (wr_fsel) fsel_q <= bus_wdata_i[FSEL_BITS-1:0];
    end
  end

  always_comb begin
    case (bus_addr_i)
      RA_DIR:    bus_rdata_o = 32'(dir_q);
      RA_DEN:    bus_rdata_o = 32'(den_q);
      RA_ANA:    bus_rdata_o = 32'(ana_q);
      RA_PUP:    bus_rdata_o = 32'(pull_q[0]);
      RA_PDN:    bus_rdata_o = 32'(pull_q[1]);
      RA_ODN:    bus_rdata_o = 32'(odn_q);
      RA_DRV2:   bus_rdata_o = 32'(drv_q[0]);
      RA_DRV4:   bus_rdata_o = 32'(drv_q[1]);
      RA_DRV8:   bus_rdata_o = 32'(drv_q[2]);
      RA_SLEW:   bus_rdata_o = 32'(slew_q);
      RA_AFEN:   bus_rdata_o = 32'(afen_q);
      RA_FSEL:   bus_rdata_o = 32'(fsel_q);
      RA_LOCK:   bus_rdata_o = {31'b0, ~unlocked};
      RA_COMMIT: bus_rdata_o = 32'(commit);
      default:   bus_rdata_o = '0;
    endcase
  end

  assign pad_dir_o  = dir_q;
  assign pad_den_o  = den_q;
  assign pad_ana_o  = ana_q;
  assign pad_pu_o   = pull_q[0];
  assign pad_pd_o   = pull_q[1];
  assign pad_od_o   = odn_q;
  assign pad_dr2_o  = drv_q[0];
  assign pad_dr4_o  = drv_q[1];
  assign pad_dr8_o  = drv_q[2];
  assign pad_slew_o = slew_q & drv_q[2];
  assign pad_fsel_o = fsel_q;

  for (genvar i = 0; i < NPINS; i++) begin : g_af
    assign pad_af_o[i] = afen_q[i] & (|fsel_q[i*FSEL_W +: FSEL_W]);
  end
endmodule

// File: rtl/padcfg_bank_chk.sv
module padcfg_bank_chk
  import padcfg_pkg::*;
#(
  parameter int               NPINS      = 8,
  parameter logic [NPINS-1:0] PROT_MASK  = 8'h09,
  parameter logic [31:0]      UNLOCK_KEY = 32'h4C4F434B
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               bus_we_i,
  input logic [ADDR_W-1:0]  bus_addr_i,
  input logic [31:0]        bus_wdata_i,
  input logic [NPINS-1:0]   pu,
  input logic [NPINS-1:0]   pd,
  input logic [NPINS-1:0]   dr2,
  input logic [NPINS-1:0]   dr4,
  input logic [NPINS-1:0]   dr8,
  input logic [NPINS-1:0]   slew,
  input logic [NPINS-1:0]   den,
  input logic [NPINS-1:0]   commit,
  input logic               unlocked
);
  AST_PULL_DISJOINT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pu & pd) == '0); // R2

  for (genvar i = 0; i < NPINS; i++) begin : g_drv
    AST_DRIVE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones({dr2[i], dr4[i], dr8[i]}) <= 1); // R3
  end

  AST_SLEW_NEEDS_8MA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slew & ~dr8) == '0); // R8

  AST_KEY_RELOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i == RA_LOCK && bus_wdata_i != UNLOCK_KEY)
      |=> !unlocked); // R5

  AST_COMMIT_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i == RA_COMMIT && !unlocked) |=> $stable(commit)); // R5

  AST_PROT_DEN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i == RA_DEN)
      |=> ((den ^ $past(den)) & PROT_MASK & ~$past(commit)) == '0); // R6
endmodule

bind padcfg_bank padcfg_bank_chk #(
  .NPINS(NPINS), .PROT_MASK(PROT_MASK), .UNLOCK_KEY(UNLOCK_KEY)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_we_i    (bus_we_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .pu          (pad_pu_o),
  .pd          (pad_pd_o),
  .dr2         (pad_dr2_o),
  .dr4         (pad_dr4_o),
  .dr8         (pad_dr8_o),
  .slew        (pad_slew_o),
  .den         (pad_den_o),
  .commit      (commit),
  .unlocked    (unlocked)
);

// File: tb/padcfg_bank_tb_top.sv
module padcfg_bank_tb_top;
  localparam logic [7:0]  PROT = 8'h09;
  localparam logic [31:0] KEY  = 32'h4C4F434B;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  o_dir, o_den, o_ana, o_pu, o_pd, o_od, o_dr2, o_dr4, o_dr8, o_slew, o_af;
  logic [31:0] o_fsel;

  always #2 clk = ~clk;

  padcfg_bank dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .pad_dir_o(o_dir), .pad_den_o(o_den), .pad_ana_o(o_ana), .pad_pu_o(o_pu),
    .pad_pd_o(o_pd), .pad_od_o(o_od), .pad_dr2_o(o_dr2), .pad_dr4_o(o_dr4),
    .pad_dr8_o(o_dr8), .pad_slew_o(o_slew), .pad_af_o(o_af), .pad_fsel_o(o_fsel)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference model
  logic [7:0]  m_dir, m_den, m_ana, m_pu, m_pd, m_od, m_dr2, m_dr4, m_dr8, m_slew, m_afen, m_commit;
  logic [31:0] m_fsel;
  bit          m_unl;

  task automatic model_reset();
    m_dir = 0; m_den = 8'hFF; m_ana = 0; m_pu = 0; m_pd = 0; m_od = 0;
    m_dr2 = 8'hFF; m_dr4 = 0; m_dr8 = 0; m_slew = 0; m_afen = PROT;
    m_fsel = 32'h0000_1001; m_unl = 0; m_commit = ~PROT;
  endtask

  task automatic model_write(input logic [3:0] a, input logic [31:0] d);
    logic [7:0] b, g, s;
    b = d[7:0];
    g = 8'hFF;
    for (int i = 0; i < 8; i++) if (PROT[i] && !m_commit[i]) g[i] = 1'b0;
    s = b & g;
    case (a)
      4'd0:  m_dir = b;
      4'd1:  m_den = (m_den & ~g) | s;
      4'd2:  m_ana = b;
      4'd3:  begin m_pu = (m_pu & ~g) | s; m_pd = m_pd & ~s; end
      4'd4:  begin m_pd = (m_pd & ~g) | s; m_pu = m_pu & ~s; end
      4'd5:  m_od = b;
      4'd6:  begin m_dr2 = b; m_dr4 &= ~b; m_dr8 &= ~b; end
      4'd7:  begin m_dr4 = b; m_dr2 &= ~b; m_dr8 &= ~b; end
      4'd8:  begin m_dr8 = b; m_dr2 &= ~b; m_dr4 &= ~b; end
      4'd9:  m_slew = b;
      4'd10: m_afen = (m_afen & ~g) | s;
      4'd11: m_fsel = d;
      4'd12: m_unl = (d == KEY);
      4'd13: if (m_unl) m_commit = b;
      default: ;
    endcase
  endtask

  function automatic logic [31:0] model_read(input logic [3:0] a);
    case (a)
      4'd0: return {24'b0, m_dir};   4'd1: return {24'b0, m_den};
      4'd2: return {24'b0, m_ana};   4'd3: return {24'b0, m_pu};
      4'd4: return {24'b0, m_pd};    4'd5: return {24'b0, m_od};
      4'd6: return {24'b0, m_dr2};   4'd7: return {24'b0, m_dr4};
      4'd8: return {24'b0, m_dr8};   4'd9: return {24'b0, m_slew};
      4'd10: return {24'b0, m_afen}; 4'd11: return m_fsel;
      4'd12: return {31'b0, !m_unl}; 4'd13: return {24'b0, m_commit};
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [7:0] model_af();
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = m_afen[i] && (m_fsel[4*i +: 4] != 4'h0);
    return r;
  endfunction

  function automatic string req_of(input logic [3:0] a);
    case (a)
      4'd1, 4'd10:       return "R6";
      4'd3, 4'd4:        return "R2";
      4'd6, 4'd7, 4'd8:  return "R3";
      4'd11:             return "R7";
      4'd12:             return "R5";
      4'd13:             return "R9";
      4'd14, 4'd15:      return "R1";
      default:           return "R10";
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
    model_write(a, d);
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic check_reg(input string req, input logic [3:0] a);
    logic [31:0] d;
    bus_read(a, d);
    check(req, $sformatf("read offset %0d", a), d, model_read(a));
  endtask

  task automatic check_outputs();
    check("R10", "static outputs", {o_dir, o_ana, o_od, o_fsel[7:0]},
          {m_dir, m_ana, m_od, m_fsel[7:0]});
    check("R2", "pull outputs", {16'b0, o_pu, o_pd}, {16'b0, m_pu, m_pd});
    check("R3", "drive outputs", {8'b0, o_dr2, o_dr4, o_dr8}, {8'b0, m_dr2, m_dr4, m_dr8});
    check("R8", "slew output", {24'b0, o_slew}, {24'b0, m_slew & m_dr8});
    check("R7", "af output", {24'b0, o_af}, {24'b0, model_af()});
    check("R6", "den output", {24'b0, o_den}, {24'b0, m_den});
  endtask

  initial begin
    logic [31:0] d;
    model_reset();
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R4 reset state
    for (int a = 0; a < 16; a++) check_reg("R4", 4'(a));
    check("R4", "reset af", {24'b0, o_af}, 32'h09);
    check("R4", "reset dr2", {24'b0, o_dr2}, 32'hFF);
    check_outputs();

    // R5 commit write while locked is ignored
    bus_write(4'd13, 32'hFF);
    bus_read(4'd13, d); check("R5", "commit while locked", d, 32'hF6);
    // R6 gated writes on protected pins
    bus_write(4'd1, 32'h00);
    bus_read(4'd1, d); check("R6", "den gated", d, 32'h09);
    bus_write(4'd3, 32'hFF);
    bus_read(4'd3, d); check("R6", "pup gated", d, 32'hF6);
    bus_write(4'd4, 32'h01);
    bus_read(4'd4, d); check("R6", "pdn gated", d, 32'h00);
    bus_read(4'd3, d); check("R6", "pup kept", d, 32'hF6);
    // R5 unlock / relock
    bus_write(4'd12, KEY);
    bus_read(4'd12, d); check("R5", "lock reads unlocked", d, 32'h0);
    bus_write(4'd13, 32'hFF);
    bus_write(4'd12, 32'h0);
    bus_read(4'd12, d); check("R5", "lock reads locked", d, 32'h1);
    // R9 committed pins are writable
    bus_write(4'd1, 32'h00);
    bus_read(4'd1, d); check("R9", "den after commit", d, 32'h00);
    // R7 zero function number gives no alternate function
    bus_write(4'd10, 32'hFF);
    bus_write(4'd11, 32'h0000_00F0);
    check("R7", "af with zero fields", {24'b0, o_af}, 32'h02);
    // R8 / R3 slew follows 8 mA
    bus_write(4'd9, 32'hFF);
    bus_write(4'd8, 32'h0F);
    check("R8", "slew with 8mA", {24'b0, o_slew}, 32'h0F);
    bus_write(4'd6, 32'h01);
    check("R8", "slew after 8mA cleared", {24'b0, o_slew}, 32'h0E);
    bus_read(4'd8, d); check("R3", "drv8 cleared", d, 32'h0E);
    // R1 unmapped offsets
    check_reg("R1", 4'd14);
    check_reg("R1", 4'd15);
    check_outputs();

    // relock with fresh protection for random phase
    bus_write(4'd12, KEY);
    bus_write(4'd13, 32'hF6);
    bus_write(4'd12, 32'h1);

    for (int it = 0; it < 400; it++) begin
      logic [3:0]  a;
      logic [31:0] v;
      a = 4'($urandom_range(0, 15));
      v = $urandom;
      if (a == 4'd12 && $urandom_range(0, 1) == 1) v = KEY;
      bus_write(a, v);
      check_reg(req_of(a), a);
      begin
        logic [3:0] b;
        b = 4'($urandom_range(0, 15));
        check_reg(req_of(b), b);
      end
      check_outputs();
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule